// File: doc/BRIEF.md
# SDRAM Command Sequence Checker

This block watches the command pins of a four-bank SDRAM interface and reports the first protocol rule that a memory controller breaks. It is passive: it drives nothing onto the memory bus. Its only outputs are a sticky flag, a code that names the broken rule, and the cycle index at which the rule was broken. It can sit beside a controller in simulation or be built into an FPGA image as a bus watchdog.

On every rising clock edge the checker decodes the chip-select, row strobe, column strobe and write-enable pins into one command. For each bank it keeps a small record: whether the bank is open, how long ago it was activated, how long ago it was closed, how long ago its last write beat ended, and whether a burst with auto precharge is still in progress. Global counters measure the time since the last mode-register load. A command is checked against this record before the record is updated. Spacing limits are given in clock cycles through parameters.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Pins {cs_n,ras_n,cas_n,we_n} decode as 0000 mode load, 0001 refresh, 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge and 0111 no-op. cs_n high is a deselect. While cke is low the sample counts as no command. No-op, deselect and cke-low cycles never raise a violation.
- R2: After reset, viol is 0, err_code is 0 and err_cycle is 0. The cycle index is 0 at the third rising edge after rst_n rises, and it increases by one on each later edge.
- R3: A mode load or refresh while any bank is open raises code 1.
- R4: Any command other than no-op or deselect issued fewer than T_MRD cycles after a mode load raises code 2.
- R5: An activate to a bank that is already open raises code 3. A read or write to a closed bank raises code 4.
- R6: An activate to a bank fewer than T_RC cycles after that bank's previous activate raises code 5. An activate fewer than T_RRD cycles after an activate to any other bank raises code 6.
- R7: A read or write fewer than T_RCD cycles after its bank's activate raises code 7. A precharge of an open bank fewer than T_RAS cycles after its activate raises code 8.
- R8: The last write beat falls BURST_LEN-1 cycles after the write command. A precharge of that open bank fewer than T_RDL cycles after the last beat raises code 9. An activate of that bank fewer than T_DAL cycles after the last beat raises code 10.
- R9: A read or write with a10 high starts a burst with auto precharge. A further read or write to that bank before the burst's last beat raises code 11. The bank closes at the last beat. An activate fewer than T_RP cycles after a bank closed, by precharge or by auto precharge, raises code 12.
- R10: A precharge with a10 high closes every bank and ignores ba.
- R11: Only the first violation is captured. viol, err_code and err_cycle then hold until reset, and later violations do not change them.
- R12: When one command breaks several rules, the lowest code is reported.
- R13: A sequence that meets every spacing limit, including limits met exactly, raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| a10 | input | 1 | Address bit 10: precharge-all and auto-precharge select |
| viol | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first broken rule |
| err_cycle | output | CYC_W | Cycle index of the offending command |

## Verification
Each rule is provoked by a short command sequence that breaks that rule and no other, or that breaks two rules when the priority between them is under test. The bench then compares the reported code and cycle index. A legal sequence meets several limits exactly and includes cke-low and deselected cycles that carry command-like pin values; it separates an off-by-one limit from a correct one and shows that such cycles are ignored. A precharge-all sent with an unrelated bank address is followed by a read to a bank that was open, which shows that ba was ignored. A second rule break after the first one shows that the captured record does not change.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_MRS, CMD_REF, CMD_ACT,
    CMD_RD, CMD_WR, CMD_BST, CMD_PRE
  } cmd_e;

  // Rule codes; a lower value wins when several rules fire together.
  typedef enum logic [3:0] {
    ERR_NONE       = 4'd0,
    ERR_CFG_OPEN   = 4'd1,
    ERR_CFG_GAP    = 4'd2,
    ERR_ACT_OPEN   = 4'd3,
    ERR_ACC_CLOSED = 4'd4,
    ERR_RC         = 4'd5,
    ERR_RRD        = 4'd6,
    ERR_RCD        = 4'd7,
    ERR_RAS        = 4'd8,
    ERR_WR_PRE     = 4'd9,
    ERR_WR_ACT     = 4'd10,
    ERR_AP_BUSY    = 4'd11,
    ERR_RP         = 4'd12
  } err_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_DESEL;
    if (cke && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int AGE_W     = 6,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_act,
  input  logic             en_rw,
  input  logic             rw_is_wr,
  input  logic             rw_ap,
  input  logic             en_pre,
  output logic             open_o,
  output logic [AGE_W-1:0] act_age_o,
  output logic [AGE_W-1:0] close_age_o,
  output logic [AGE_W-1:0] wd_age_o,
  output logic             ap_busy_o
);

  localparam int BEAT_W = $clog2(BURST_LEN + 1);
  localparam logic [AGE_W-1:0]  AGE_MAX = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0]  AGE_ONE = AGE_W'(1);
  localparam logic [BEAT_W-1:0] BEAT_LD = BEAT_W'(BURST_LEN - 1);
  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  logic              open_q, open_d;
  logic [AGE_W-1:0]  act_q, act_d, close_q, close_d, wd_q, wd_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              bwr_q, bwr_d, bap_q, bap_d, busy_q, busy_d;
  logic              last_beat, cur_wr, cur_ap;

  function automatic logic [AGE_W-1:0] age_inc(input logic [AGE_W-1:0] a);
    return (a == AGE_MAX) ? a : a + AGE_ONE;
  endfunction

  always_comb begin
    cur_wr    = en_rw ? rw_is_wr : bwr_q;
    cur_ap    = en_rw ? rw_ap : bap_q;
    last_beat = en_rw ? (BURST_LEN == 1) : (beat_q == BEAT_ONE);

    beat_d = beat_q;
    if (en_rw)             beat_d = BEAT_LD;
    else if (beat_q != '0) beat_d = beat_q - BEAT_ONE;
    bwr_d = cur_wr;
    bap_d = cur_ap;

    busy_d = busy_q;
    if (en_rw)     busy_d = rw_ap;
    if (last_beat) busy_d = 1'b0;

    act_d = en_act ? AGE_ONE : age_inc(act_q);
    wd_d  = (last_beat && cur_wr) ? AGE_ONE : age_inc(wd_q);

    close_d = age_inc(close_q);
    if ((en_pre && open_q) || (last_beat && cur_ap)) close_d = AGE_ONE;

    open_d = open_q;
    if (en_pre || (last_beat && cur_ap)) open_d = 1'b0;
    if (en_act)                          open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      act_q   <= AGE_MAX;
      close_q <= AGE_MAX;
      wd_q    <= AGE_MAX;
      beat_q  <= '0;
      bwr_q   <= 1'b0;
      bap_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      open_q  <= open_d;
      act_q   <= act_d;
      close_q <= close_d;
      wd_q    <= wd_d;
      beat_q  <= beat_d;
      bwr_q   <= bwr_d;
      bap_q   <= bap_d;
      busy_q  <= busy_d;
    end
  end

  assign open_o      = open_q;
  assign act_age_o   = act_q;
  assign close_age_o = close_q;
  assign wd_age_o    = wd_q;
  assign ap_busy_o   = busy_q;

  AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    en_act |=> open_q); // R5
  AST_AP_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && cur_ap && !en_act) |=> (!open_q && !busy_q)); // R9

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int T_RDL     = 2,
  parameter int T_DAL     = T_RDL + T_RP,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4,
  parameter int CYC_W     = 32,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic              a10,
  output logic              viol,
  output logic [3:0]        err_code,
  output logic [CYC_W-1:0]  err_cycle
);

  localparam int T_MAX = imax(imax(imax(T_RC, T_RRD), imax(T_RCD, T_RAS)),
                              imax(imax(T_RP, T_RDL), imax(T_DAL, T_MRD)));
  localparam int AGE_W = $clog2(T_MAX + 1) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);
  localparam logic [AGE_W-1:0] L_RC  = AGE_W'(T_RC);
  localparam logic [AGE_W-1:0] L_RRD = AGE_W'(T_RRD);
  localparam logic [AGE_W-1:0] L_RCD = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0] L_RAS = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] L_RP  = AGE_W'(T_RP);
  localparam logic [AGE_W-1:0] L_RDL = AGE_W'(T_RDL);
  localparam logic [AGE_W-1:0] L_DAL = AGE_W'(T_DAL);
  localparam logic [AGE_W-1:0] L_MRD = AGE_W'(T_MRD);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cmd_e cmd;
  sdram_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  logic [NUM_BANKS-1:0] en_act, en_rw, en_pre, open_bits, busy_bits;
  logic [AGE_W-1:0]     act_age [NUM_BANKS];
  logic [AGE_W-1:0]     close_age [NUM_BANKS];
  logic [AGE_W-1:0]     wd_age [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign en_act[g] = (cmd == CMD_ACT) && (ba == BANK_W'(g));
    assign en_rw[g]  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && (ba == BANK_W'(g));
    assign en_pre[g] = (cmd == CMD_PRE) && (a10 || (ba == BANK_W'(g)));
    sdram_bank_state #(.AGE_W(AGE_W), .BURST_LEN(BURST_LEN)) u_bank (
      .clk(clk), .rst_n(rst_sync),
      .en_act(en_act[g]), .en_rw(en_rw[g]), .rw_is_wr(cmd == CMD_WR),
      .rw_ap(a10), .en_pre(en_pre[g]),
      .open_o(open_bits[g]), .act_age_o(act_age[g]),
      .close_age_o(close_age[g]), .wd_age_o(wd_age[g]),
      .ap_busy_o(busy_bits[g])
    );
  end

  // Time since last mode load, free-running cycle index
  logic [AGE_W-1:0] mrs_q, mrs_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;

  always_comb begin
    mrs_d = (mrs_q == AGE_MAX) ? mrs_q : mrs_q + AGE_ONE;
    if (cmd == CMD_MRS) mrs_d = AGE_ONE;
    cyc_d = cyc_q + CYC_W'(1);
  end

  // Rule evaluation against state before this command takes effect
  logic [15:0] hit;
  logic [3:0]  first_code;

  always_comb begin
    hit = '0;
    unique case (cmd)
      CMD_MRS, CMD_REF: if (|open_bits) hit[ERR_CFG_OPEN] = 1'b1;
      CMD_ACT: begin
        if (open_bits[ba])        hit[ERR_ACT_OPEN] = 1'b1;
        if (act_age[ba] < L_RC)   hit[ERR_RC]       = 1'b1;
        if (wd_age[ba] < L_DAL)   hit[ERR_WR_ACT]   = 1'b1;
        if (close_age[ba] < L_RP) hit[ERR_RP]       = 1'b1;
        for (int j = 0; j < NUM_BANKS; j++)
          if ((ba != BANK_W'(j)) && (act_age[j] < L_RRD)) hit[ERR_RRD] = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if (!open_bits[ba])       hit[ERR_ACC_CLOSED] = 1'b1;
        if (busy_bits[ba])        hit[ERR_AP_BUSY]    = 1'b1;
        if (act_age[ba] < L_RCD)  hit[ERR_RCD]        = 1'b1;
      end
      CMD_PRE: begin
        for (int j = 0; j < NUM_BANKS; j++) begin
          if (en_pre[j] && open_bits[j] && (act_age[j] < L_RAS)) hit[ERR_RAS]    = 1'b1;
          if (en_pre[j] && open_bits[j] && (wd_age[j] < L_RDL))  hit[ERR_WR_PRE] = 1'b1;
        end
      end
      default: ;
    endcase
    if ((cmd != CMD_NOP) && (cmd != CMD_DESEL) && (mrs_q < L_MRD))
      hit[ERR_CFG_GAP] = 1'b1;

    first_code = ERR_NONE;
    for (int k = 15; k >= 1; k--)
      if (hit[k]) first_code = 4'(k);
  end

  // First-violation capture
  logic             viol_q, viol_d;
  logic [3:0]       code_q, code_d;
  logic [CYC_W-1:0] ecyc_q, ecyc_d;
  logic             cap_en;

  always_comb begin
    cap_en = !viol_q && (first_code != ERR_NONE);
    viol_d = viol_q;
    code_d = code_q;
    ecyc_d = ecyc_q;
    if (cap_en) begin
      viol_d = 1'b1;
      code_d = first_code;
      ecyc_d = cyc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      mrs_q  <= AGE_MAX;
      cyc_q  <= '0;
      viol_q <= 1'b0;
      code_q <= ERR_NONE;
      ecyc_q <= '0;
    end else begin
      mrs_q <= mrs_d;
      cyc_q <= cyc_d;
      if (cap_en) begin
        viol_q <= viol_d;
        code_q <= code_d;
        ecyc_q <= ecyc_d;
      end
    end
  end

  assign viol      = viol_q;
  assign err_code  = code_q;
  assign err_cycle = ecyc_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_sync)
    viol_q |=> (viol_q && $stable(code_q) && $stable(ecyc_q))); // R11
  AST_FLAG_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_sync)
    viol_q |-> (code_q != ERR_NONE)); // R11
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_sync)
    (!viol_q && ((cmd == CMD_NOP) || (cmd == CMD_DESEL))) |=> !viol_q); // R1
  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_sync)
    ((cmd == CMD_PRE) && a10) |=> (open_bits == '0)); // R10
  AST_CFG_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_sync)
    (!viol_q && ((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|open_bits))
      |=> (viol_q && (code_q == ERR_CFG_OPEN))); // R3

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

  localparam logic [3:0] P_MRS = 4'b0000, P_REF = 4'b0001, P_ACT = 4'b0011,
                         P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                         P_NOP = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic        a10 = 1'b0;
  logic        viol;
  logic [3:0]  err_code;
  logic [31:0] err_cycle;

  int checks = 0;
  int fails  = 0;
  int tb_cyc = 0;

  always #4 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .viol(viol), .err_code(err_code), .err_cycle(err_cycle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_err(input string req, input bit v, input int code, input int cyc);
    chk({req, " flag"}, {31'd0, viol}, {31'd0, v});
    chk({req, " code"}, {28'd0, err_code}, code);
    if (v) chk({req, " cycle"}, err_cycle, cyc);
  endtask

  task automatic set_pins(input logic [3:0] p, input int b, input bit hi10, input bit ck);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba  = 2'(b);
    a10 = hi10;
    cke = ck;
  endtask

  task automatic issue(input logic [3:0] p, input int b, input bit hi10 = 1'b0,
                       input bit ck = 1'b1);
    set_pins(p, b, hi10, ck);
    @(negedge clk);
    tb_cyc++;
    set_pins(P_NOP, 0, 1'b0, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tb_cyc++;
    end
  endtask

  task automatic do_reset;
    set_pins(P_NOP, 0, 1'b0, 1'b1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    tb_cyc = 0;
  endtask

  task automatic t_reset;
    do_reset();
    expect_err("R2 reset", 1'b0, 0, 0);
    chk("R2 reset cycle", err_cycle, 0);
  endtask

  task automatic t_legal;
    do_reset();
    issue(P_MRS, 0);                 // c0
    issue(P_NOP, 0);                 // c1
    issue(P_ACT, 0);                 // c2, mode gap met exactly
    idle(2);
    issue(P_RD, 0);                  // c5, T_RCD met exactly
    issue(P_ACT, 0, 1'b0, 1'b0);     // c6, cke low: ignored (R1)
    set_pins(4'b1000, 0, 1'b0, 1'b1);
    idle(1);                         // c7, deselected pins: ignored (R1)
    issue(P_PRE, 0);                 // c8
    issue(P_ACT, 1);                 // c9
    idle(1);
    issue(P_ACT, 2);                 // c11, T_RRD met exactly
    issue(P_RD, 1);                  // c12
    expect_err("R13 R1 legal sequence", 1'b0, 0, 0);
  endtask

  task automatic t_cfg_open;
    do_reset();
    issue(P_ACT, 2); idle(3);
    issue(P_REF, 0);                 // c4
    expect_err("R3 refresh with open bank", 1'b1, 1, 4);
  endtask

  task automatic t_mrd;
    do_reset();
    issue(P_MRS, 0);
    issue(P_ACT, 0);                 // c1
    expect_err("R4 command after mode load", 1'b1, 2, 1);
  endtask

  task automatic t_act_open;
    do_reset();
    issue(P_ACT, 1); idle(8);
    issue(P_ACT, 1);                 // c9
    expect_err("R5 activate open bank", 1'b1, 3, 9);
  endtask

  task automatic t_closed;
    do_reset();
    issue(P_RD, 3);                  // c0
    expect_err("R5 read closed bank", 1'b1, 4, 0);
  endtask

  task automatic t_trc;
    do_reset();
    issue(P_ACT, 0); idle(4);
    issue(P_PRE, 0);                 // c5
    idle(2);
    issue(P_ACT, 0);                 // c8: row precharge met, cycle limit not
    expect_err("R6 same bank activate spacing", 1'b1, 5, 8);
  endtask

  task automatic t_trrd;
    do_reset();
    issue(P_ACT, 0);
    issue(P_ACT, 1);                 // c1
    expect_err("R6 cross bank activate spacing", 1'b1, 6, 1);
  endtask

  task automatic t_trcd;
    do_reset();
    issue(P_ACT, 2); idle(1);
    issue(P_WR, 2);                  // c2
    expect_err("R7 access too soon", 1'b1, 7, 2);
  endtask

  task automatic t_tras;
    do_reset();
    issue(P_ACT, 3); idle(3);
    issue(P_PRE, 3);                 // c4
    expect_err("R7 precharge too soon", 1'b1, 8, 4);
  endtask

  task automatic t_trdl;
    do_reset();
    issue(P_ACT, 0); idle(2);
    issue(P_WR, 0);                  // c3, last beat c6
    idle(3);
    issue(P_PRE, 0);                 // c7
    expect_err("R8 precharge after write data", 1'b1, 9, 7);
  endtask

  task automatic t_tdal;
    do_reset();
    issue(P_ACT, 1); idle(2);
    issue(P_WR, 1);                  // c3, last beat c6
    idle(4);
    issue(P_PRE, 1);                 // c8, write recovery met exactly
    expect_err("R8 precharge at limit", 1'b0, 0, 0);
    issue(P_ACT, 1);                 // c9
    expect_err("R8 activate after write data", 1'b1, 10, 9);
  endtask

  task automatic t_ap_busy;
    do_reset();
    issue(P_ACT, 2); idle(2);
    issue(P_RD, 2, 1'b1);            // c3, burst to c6
    idle(1);
    issue(P_RD, 2);                  // c5
    expect_err("R9 access during auto precharge", 1'b1, 11, 5);
  endtask

  task automatic t_ap_trp;
    do_reset();
    issue(P_ACT, 2); idle(4);
    issue(P_RD, 2, 1'b1);            // c5, closes at c8
    idle(4);
    issue(P_ACT, 2);                 // c10
    expect_err("R9 activate after auto precharge", 1'b1, 12, 10);
  endtask

  task automatic t_pre_all;
    do_reset();
    issue(P_ACT, 0); idle(1);
    issue(P_ACT, 1); idle(4);
    issue(P_PRE, 3, 1'b1);           // c7, ba names a closed bank
    expect_err("R10 precharge all legal", 1'b0, 0, 0);
    issue(P_RD, 1);                  // c8
    expect_err("R10 bank closed by precharge all", 1'b1, 4, 8);
  endtask

  task automatic t_priority;
    do_reset();
    issue(P_ACT, 0); idle(4);
    issue(P_PRE, 0);                 // c5
    issue(P_ACT, 0);                 // c6: codes 5 and 12 together
    expect_err("R12 lowest code wins", 1'b1, 5, 6);
  endtask

  task automatic t_sticky;
    do_reset();
    issue(P_RD, 0);                  // c0: code 4
    issue(P_ACT, 0);
    issue(P_ACT, 1);                 // c2: would be code 6
    expect_err("R11 first violation held", 1'b1, 4, 0);
    do_reset();
    expect_err("R11 cleared by reset", 1'b0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_legal();
    t_cfg_open();
    t_mrd();
    t_act_open();
    t_closed();
    t_trc();
    t_trrd();
    t_trcd();
    t_tras();
    t_trdl();
    t_tdal();
    t_ap_busy();
    t_ap_trp();
    t_pre_all();
    t_priority();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule